// File: doc/BRIEF.md
# Bridge Secondary Status Register

This block holds the 16-bit status register that records error conditions seen on the secondary side of a virtual PCI-to-PCI bridge. The receive path gives it one-cycle event strobes: a poisoned-packet flag, a flag marking a read-data completion, fatal and non-fatal error-message indications, and a completion status with a flag that marks completions for requests the bridge issued itself. The parity error response enable from the bridge control register is a further input. Each event sets its own sticky bit. The bit then stays set until software writes a one to it.

Software reaches the register through a 32-bit configuration port. The port has a dword address and four byte enables. The register occupies byte offsets 1Eh and 1Fh, which is the upper half of dword 7. The status value therefore appears on data bits 31:16, and byte enables 2 and 3 select its low and high bytes. A read returns the value combinationally while the read strobe is high. Writes take effect at the clock edge.

Top module: `bridge_sec_status`

## Requirements
- R1: After a synchronous reset, the register reads 0000h.
- R2: Bit 15 sets in the cycle after a poisoned packet is received, whatever the parity error response enable is.
- R3: Bit 14 sets in the cycle after a fatal or a non-fatal error message is received.
- R4: Bit 13 sets after a completion arrives with status Unsupported Request (3'b001) for a request the bridge issued itself.
- R5: Bit 12 sets after a completion arrives with status Completer Abort (3'b100) for a request the bridge issued itself.
- R6: A completion for a request the bridge did not issue sets neither bit 13 nor bit 12. A Successful completion (3'b000) sets neither bit, whoever issued the request.
- R7: Bit 8 sets after a poisoned read-data completion, and only when the parity error response enable is 1.
- R8: Bits 15 to 12 and bit 8 are cleared by writing one to them. Writing zero to a bit leaves it unchanged.
- R9: A write affects only the bytes whose byte enable is set. Enable 2 covers bits 7:0 and enable 3 covers bits 15:8, both on data bits 31:16. A write to any dword address other than 7 has no effect.
- R10: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R11: Bits 11:9 and 7:0 always read zero. Read data is {status, 16'h0000} while the read strobe is high and the address is 7. Otherwise read data is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_poisoned | input | 1 | Received packet is poisoned |
| rx_rd_cpl | input | 1 | Received packet is a read-data completion |
| rx_err_fatal | input | 1 | Fatal error message received |
| rx_err_nonfatal | input | 1 | Non-fatal error message received |
| rx_cpl_valid | input | 1 | Completion status below is valid |
| rx_cpl_own | input | 1 | Completion answers a request the bridge issued |
| rx_cpl_status | input | 3 | Completion status code |
| perr_resp_en | input | 1 | Parity error response enable |
| cfg_addr | input | 10 | Configuration dword address |
| cfg_be | input | 4 | Byte enables |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Read data |

## Verification
A bit stuck at one, or one that fails to set, shows up on the first read after the event. The register sets in the cycle after the strobe, so that read can come one cycle later. An event steered to the wrong bit shows up as a wrong value in a single-event read. A clear mask shifted by one byte shows up after one partial write. If clear takes priority over set, a combined set and clear leaves the bit at zero, and this shows up in the very next read.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int STAT_W   = 16;
    localparam int BIT_DPE  = 15;
    localparam int BIT_RSE  = 14;
    localparam int BIT_RMA  = 13;
    localparam int BIT_RTA  = 12;
    localparam int BIT_MDPE = 8;

    localparam logic [STAT_W-1:0] IMPL_MASK =
        (16'd1 << BIT_DPE) | (16'd1 << BIT_RSE) | (16'd1 << BIT_RMA) |
        (16'd1 << BIT_RTA) | (16'd1 << BIT_MDPE);

    typedef enum logic [2:0] {
        CPL_SC  = 3'b000,
        CPL_UR  = 3'b001,
        CPL_CRS = 3'b010,
        CPL_CA  = 3'b100
    } cpl_stat_e;

    typedef struct packed {
        logic       poisoned;
        logic       rd_cpl;
        logic       err_fatal;
        logic       err_nonfatal;
        logic       cpl_valid;
        logic       cpl_own;
        logic [2:0] cpl_status;
    } rx_evt_t;

    function automatic logic [STAT_W-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/bss_event_decode.sv
module bss_event_decode
    import bss_pkg::*;
(
    input  rx_evt_t           evt,
    input  logic              perr_en,
    output logic [STAT_W-1:0] set_vec
);
    logic own_cpl;

    always_comb begin
        own_cpl  = evt.cpl_valid && evt.cpl_own;
        set_vec  = '0;
        set_vec[BIT_DPE]  = evt.poisoned;
        set_vec[BIT_RSE]  = evt.err_fatal || evt.err_nonfatal;
        set_vec[BIT_RMA]  = own_cpl && (evt.cpl_status == CPL_UR);
        set_vec[BIT_RTA]  = own_cpl && (evt.cpl_status == CPL_CA);
        set_vec[BIT_MDPE] = evt.poisoned && evt.rd_cpl && perr_en;
    end
endmodule

// File: rtl/bss_w1c_bit.sv
module bss_w1c_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/bridge_sec_status.sv
module bridge_sec_status
    import bss_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 32,
    parameter int REG_BYTE_OFS = 'h1E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_poisoned,
    input  logic              rx_rd_cpl,
    input  logic              rx_err_fatal,
    input  logic              rx_err_nonfatal,
    input  logic              rx_cpl_valid,
    input  logic              rx_cpl_own,
    input  logic [2:0]        rx_cpl_status,
    input  logic              perr_resp_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_rd,
    output logic [DATA_W-1:0] cfg_rdata
);
    localparam int BYTES   = DATA_W / 8;
    localparam int DW_IDX  = REG_BYTE_OFS / BYTES;
    localparam int LANE    = REG_BYTE_OFS % BYTES;
    localparam int BIT_OFS = LANE * 8;

    rx_evt_t           evt;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] status_q;
    logic              hit;

    assign evt = '{poisoned:     rx_poisoned,
                   rd_cpl:       rx_rd_cpl,
                   err_fatal:    rx_err_fatal,
                   err_nonfatal: rx_err_nonfatal,
                   cpl_valid:    rx_cpl_valid,
                   cpl_own:      rx_cpl_own,
                   cpl_status:   rx_cpl_status};

    assign hit = (cfg_addr == ADDR_W'(DW_IDX));

    bss_event_decode u_dec (
        .evt     (evt),
        .perr_en (perr_resp_en),
        .set_vec (set_vec)
    );

    always_comb begin
        clr_vec = '0;
        if (cfg_wr && hit)
            clr_vec = cfg_wdata[BIT_OFS +: STAT_W] &
                      lane_mask(cfg_be[LANE +: 2]);
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_sticky
            bss_w1c_bit u_bit (
                .clk   (clk),
                .rst   (rst),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q     (status_q[i])
            );
        end else begin : g_zero
            assign status_q[i] = 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd && hit)
            cfg_rdata[BIT_OFS +: STAT_W] = status_q;
    end
endmodule

// File: rtl/bss_checker.sv
module bss_checker (
    input logic        clk,
    input logic        rst,
    input logic        rx_poisoned,
    input logic        rx_rd_cpl,
    input logic        rx_err_fatal,
    input logic        rx_err_nonfatal,
    input logic        rx_cpl_valid,
    input logic        rx_cpl_own,
    input logic [2:0]  rx_cpl_status,
    input logic        perr_resp_en,
    input logic [9:0]  cfg_addr,
    input logic [3:0]  cfg_be,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic        cfg_rd,
    input logic [31:0] cfg_rdata,
    input logic [15:0] status
);
    logic any_evt;
    logic wr_here;
    assign any_evt = rx_poisoned || rx_err_fatal || rx_err_nonfatal || rx_cpl_valid;
    assign wr_here = cfg_wr && (cfg_addr == 10'd7) && (cfg_be[3:2] != 2'b00);

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> status == 16'h0000);

    a_r2_poison_sets: assert property (@(posedge clk) disable iff (rst)
        rx_poisoned |=> status[15]);

    a_r3_errmsg_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_err_fatal || rx_err_nonfatal) |=> status[14]);

    a_r4_ur_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_cpl_valid && rx_cpl_own && rx_cpl_status == 3'b001) |=> status[13]);

    a_r5_ca_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_cpl_valid && rx_cpl_own && rx_cpl_status == 3'b100) |=> status[12]);

    a_r7_mdpe_gated: assert property (@(posedge clk) disable iff (rst)
        (!status[8] && !perr_resp_en) |=> !status[8]);

    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (!any_evt && !wr_here) |=> $stable(status));

    a_r11_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15:0] == 16'h0000) && (cfg_rdata[27:25] == 3'b000) &&
        (cfg_rdata[23:16] == 8'h00) && (cfg_rd || cfg_rdata == 32'h0));
endmodule

bind bridge_sec_status bss_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .rx_poisoned     (rx_poisoned),
    .rx_rd_cpl       (rx_rd_cpl),
    .rx_err_fatal    (rx_err_fatal),
    .rx_err_nonfatal (rx_err_nonfatal),
    .rx_cpl_valid    (rx_cpl_valid),
    .rx_cpl_own      (rx_cpl_own),
    .rx_cpl_status   (rx_cpl_status),
    .perr_resp_en    (perr_resp_en),
    .cfg_addr        (cfg_addr),
    .cfg_be          (cfg_be),
    .cfg_wr          (cfg_wr),
    .cfg_wdata       (cfg_wdata),
    .cfg_rd          (cfg_rd),
    .cfg_rdata       (cfg_rdata),
    .status          (status_q)
);

// File: tb/bridge_sec_status_bench.sv
module bridge_sec_status_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_poisoned = 0, rx_rd_cpl = 0, rx_err_fatal = 0, rx_err_nonfatal = 0;
    logic        rx_cpl_valid = 0, rx_cpl_own = 0;
    logic [2:0]  rx_cpl_status = 3'b000;
    logic        perr_resp_en = 0;
    logic [9:0]  cfg_addr = 10'd0;
    logic [3:0]  cfg_be = 4'h0;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bridge_sec_status u_bridge_sec_status (
        .clk, .rst, .rx_poisoned, .rx_rd_cpl, .rx_err_fatal, .rx_err_nonfatal,
        .rx_cpl_valid, .rx_cpl_own, .rx_cpl_status, .perr_resp_en,
        .cfg_addr, .cfg_be, .cfg_wr, .cfg_wdata, .cfg_rd, .cfg_rdata
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_raw(input logic [9:0] a, output logic [31:0] d);
        cfg_addr = a; cfg_rd = 1'b1;
        #1 d = cfg_rdata;
        cfg_rd = 1'b0;
    endtask

    task automatic expect_status(input string req, input logic [15:0] exp);
        logic [31:0] d;
        rd_raw(10'd7, d);
        check(req, d, {exp, 16'h0000});
    endtask

    task automatic idle_inputs();
        rx_poisoned = 0; rx_rd_cpl = 0; rx_err_fatal = 0; rx_err_nonfatal = 0;
        rx_cpl_valid = 0; rx_cpl_own = 0; rx_cpl_status = 3'b000; cfg_wr = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic cfg_write(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        step();
    endtask

    task automatic cpl(input logic own, input logic [2:0] st);
        @(negedge clk);
        rx_cpl_valid = 1; rx_cpl_own = own; rx_cpl_status = st;
        step();
    endtask

    task automatic clear_all();
        cfg_write(10'd7, 4'hC, 32'hFFFF_0000);
    endtask

    task automatic t_reset();
        expect_status("R1 reset value", 16'h0000);
    endtask

    task automatic t_poison();
        perr_resp_en = 0;
        @(negedge clk); rx_poisoned = 1; step();
        expect_status("R2 poison with enable 0", 16'h8000);
        clear_all();
        expect_status("R8 clear bit 15", 16'h0000);
    endtask

    task automatic t_errmsg();
        @(negedge clk); rx_err_fatal = 1; step();
        expect_status("R3 fatal message", 16'h4000);
        clear_all();
        @(negedge clk); rx_err_nonfatal = 1; step();
        expect_status("R3 nonfatal message", 16'h4000);
        clear_all();
    endtask

    task automatic t_cpl();
        cpl(1, 3'b001);
        expect_status("R4 own UR completion", 16'h2000);
        clear_all();
        cpl(1, 3'b100);
        expect_status("R5 own CA completion", 16'h1000);
        clear_all();
        cpl(0, 3'b001);
        cpl(0, 3'b100);
        cpl(1, 3'b000);
        expect_status("R6 foreign or successful completions", 16'h0000);
    endtask

    task automatic t_mdpe();
        perr_resp_en = 0;
        @(negedge clk); rx_poisoned = 1; rx_rd_cpl = 1; step();
        expect_status("R7 poisoned read cpl enable 0", 16'h8000);
        clear_all();
        perr_resp_en = 1;
        @(negedge clk); rx_poisoned = 1; rx_rd_cpl = 1; step();
        expect_status("R7 poisoned read cpl enable 1", 16'h8100);
        perr_resp_en = 0;
        clear_all();
    endtask

    task automatic fill_all();
        perr_resp_en = 1;
        @(negedge clk); rx_poisoned = 1; rx_rd_cpl = 1; rx_err_fatal = 1; step();
        perr_resp_en = 0;
        cpl(1, 3'b001);
        cpl(1, 3'b100);
    endtask

    task automatic t_w1c();
        fill_all();
        expect_status("R8 all bits set", 16'hF100);
        cfg_write(10'd7, 4'hC, 32'h0000_FFFF);
        expect_status("R8 write zero keeps bits", 16'hF100);
        cfg_write(10'd7, 4'hC, 32'h8000_0000);
        expect_status("R8 clear only bit 15", 16'h7100);
        cfg_write(10'd7, 4'h4, 32'hFFFF_FFFF);
        expect_status("R9 low lane only", 16'h7100);
        cfg_write(10'd6, 4'hF, 32'hFFFF_FFFF);
        expect_status("R9 other address", 16'h7100);
        cfg_write(10'd7, 4'h8, 32'hFF00_0000);
        expect_status("R9 high lane clears", 16'h0000);
    endtask

    task automatic t_setwins();
        @(negedge clk); rx_poisoned = 1; step();
        @(negedge clk);
        rx_poisoned = 1; rx_err_fatal = 1;
        cfg_addr = 10'd7; cfg_be = 4'hC; cfg_wdata = 32'hC000_0000; cfg_wr = 1;
        step();
        expect_status("R10 set beats clear", 16'hC000);
        clear_all();
    endtask

    task automatic t_read();
        logic [31:0] d;
        fill_all();
        rd_raw(10'd3, d);
        check("R11 read other address", d, 32'h0);
        cfg_addr = 10'd7; cfg_rd = 1'b0;
        #1 check("R11 no read strobe", cfg_rdata, 32'h0);
        rd_raw(10'd7, d);
        check("R11 hardwired and reserved zero", d & 32'h0EFF_FFFF, 32'h0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_poison();
        t_errmsg();
        t_cpl();
        t_mdpe();
        t_w1c();
        t_setwins();
        t_read();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule